// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This unit keeps a 64-bit signed accumulator, split into a high word and a low word, and adds one signed product to it on each operation strobe. The long form multiplies two full 32-bit signed operands. The word form multiplies only the low 16 bits of each operand, both taken as signed. A saturation-mode input, normally driven from a processor status bit, decides whether the sum is written back as it is or clamped. The clamping rule differs between the two forms.

Software or a sequencer can write either half of the accumulator directly and can zero both halves at once. Both halves can always be read on output ports. Every update is registered, so a result shows on the read ports one clock after the edge that takes it. Operand fetch and pipeline hazards belong to the surrounding core.

Top module: `sat_mac_unit`

## Requirements
- R1: After reset both accumulator halves read zero.
- R2: With op_sel=0 (long form), sat_en=0 and op_valid=1, the accumulator {acc_hi,acc_lo} becomes {acc_hi,acc_lo} plus the signed 64-bit product of opnd_a and opnd_b, modulo 2^64. A carry out of the low word goes into the high word.
- R3: With op_sel=1 (word form), sat_en=0 and op_valid=1, only opnd_a[15:0] and opnd_b[15:0] are used, sign-extended. Their product is added to the full 64-bit accumulator, and opnd_a[31:16] and opnd_b[31:16] have no effect.
- R4: In the long form with sat_en=1, a true sum below -2^47 gives 0xFFFF8000_00000000 and a true sum above 2^47-1 gives 0x00007FFF_FFFFFFFF. Any other sum is written unchanged.
- R5: In the word form with sat_en=1, a true sum below -2^31 gives acc_lo=0x80000000 and a true sum above 2^31-1 gives acc_lo=0x7FFFFFFF. In both cases acc_hi becomes 1 as an overflow marker. A sum inside the range is written unchanged.
- R6: An update happens only when op_valid is high, and its result appears after that one rising edge. With no strobe, load or clear, both halves hold their values.
- R7: acc_clr zeroes both halves and takes priority over loads and accumulates in the same cycle.
- R8: hi_ld or lo_ld writes its data word into that half and takes priority over an accumulate for that half only. The other half still takes its part of the accumulate result.
- R9: After rst_n rises, the first two rising edges leave the accumulator at zero and ignore every command. Commands take effect from the third edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on the clock |
| op_valid | input | 1 | Start one multiply-accumulate this cycle |
| op_sel | input | 1 | 0 = long form (32x32), 1 = word form (16x16) |
| opnd_a | input | 32 | First signed operand |
| opnd_b | input | 32 | Second signed operand |
| sat_en | input | 1 | Saturation mode |
| acc_clr | input | 1 | Zero both accumulator halves |
| hi_ld | input | 1 | Write hi_ld_data into the high half |
| hi_ld_data | input | 32 | Data for the high half |
| lo_ld | input | 1 | Write lo_ld_data into the low half |
| lo_ld_data | input | 32 | Data for the low half |
| acc_hi | output | 32 | High half of the accumulator |
| acc_lo | output | 32 | Low half of the accumulator |

## Verification
Each result is registered, so a wrong product, carry or clamp shows on acc_hi and acc_lo one cycle after the strobe that caused it. A 128-bit reference model checks every random step. The accumulator carries forward, so a corrupted value keeps producing mismatches until the next load or clear. Saturation errors show up as a high word outside its permitted pattern: something other than a 48-bit sign extension in the long form, or other than 0, all ones or 1 in the word form. A faulty reset release shows as a load that lands too early or too late in the first cycles after reset.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
  typedef enum logic {
    MAC_LONG = 1'b0,
    MAC_WORD = 1'b1
  } mac_op_e;
endpackage

// File: rtl/mac_product.sv
module mac_product
  import sat_mac_pkg::*;
#(
  parameter int DW = 32,
  parameter int HW = 16
) (
  input  mac_op_e                op,
  input  logic [DW-1:0]          a,
  input  logic [DW-1:0]          b,
  output logic signed [2*DW-1:0] prod
);
  localparam int AW = 2 * DW;

  logic signed [AW-1:0] wide_a;
  logic signed [AW-1:0] wide_b;

  // One multiplier serves both forms; the form only picks the sign bit.
  always_comb begin
    if (op == MAC_WORD) begin
      wide_a = {{(AW-HW){a[HW-1]}}, a[HW-1:0]};
      wide_b = {{(AW-HW){b[HW-1]}}, b[HW-1:0]};
    end else begin
      wide_a = {{DW{a[DW-1]}}, a};
      wide_b = {{DW{b[DW-1]}}, b};
    end
    prod = wide_a * wide_b;
  end
endmodule

// File: rtl/mac_saturate.sv
module mac_saturate
  import sat_mac_pkg::*;
#(
  parameter int DW    = 32,
  parameter int SAT_W = 48
) (
  input  logic [2*DW-1:0]        acc,
  input  logic signed [2*DW-1:0] prod,
  input  mac_op_e                op,
  input  logic                   sat_en,
  output logic [2*DW-1:0]        res
);
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] LONG_MAX = {{(AW-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [AW-1:0] LONG_MIN = ~LONG_MAX;
  localparam logic [DW-1:0] WORD_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] WORD_MIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] OVF_MARK = DW'(1);

  logic [AW:0] sum;
  logic        long_fits;
  logic        word_fits;
  logic        neg;

  // True sum is one bit wider than the accumulator, so no overflow is lost.
  always_comb begin
    sum       = {acc[AW-1], acc} + {prod[AW-1], prod};
    neg       = sum[AW];
    long_fits = (&sum[AW:SAT_W-1]) | ~(|sum[AW:SAT_W-1]);
    word_fits = (&sum[AW:DW-1]) | ~(|sum[AW:DW-1]);
    res       = sum[AW-1:0];
    if (sat_en) begin
      if (op == MAC_LONG) begin
        if (!long_fits) res = neg ? LONG_MIN : LONG_MAX;
      end else begin
        if (!word_fits) res = {OVF_MARK, neg ? WORD_MIN : WORD_MAX};
      end
    end
  end
endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic [DW-1:0] ld_data,
  input  logic          upd,
  input  logic [DW-1:0] upd_data,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_nxt;
  logic          q_en;

  always_comb begin
    q_en = clr | ld | upd;
    if (clr)     q_nxt = '0;
    else if (ld) q_nxt = ld_data;
    else         q_nxt = upd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit
  import sat_mac_pkg::*;
#(
  parameter int DW    = 32,
  parameter int HW    = 16,
  parameter int SAT_W = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          op_sel,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic          sat_en,
  input  logic          acc_clr,
  input  logic          hi_ld,
  input  logic [DW-1:0] hi_ld_data,
  input  logic          lo_ld,
  input  logic [DW-1:0] lo_ld_data,
  output logic [DW-1:0] acc_hi,
  output logic [DW-1:0] acc_lo
);
  localparam int AW     = 2 * DW;
  localparam int NHALF  = 2;
  localparam int SYNC_N = 2;

  // Reset asserts at once and releases on the clock.
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_N-1];

  mac_op_e              op_e;
  logic signed [AW-1:0] prod;
  logic [AW-1:0]        acc_cur;
  logic [AW-1:0]        acc_res;

  assign op_e    = mac_op_e'(op_sel);
  assign acc_cur = {acc_hi, acc_lo};

  mac_product #(.DW(DW), .HW(HW)) u_prod (
    .op   (op_e),
    .a    (opnd_a),
    .b    (opnd_b),
    .prod (prod)
  );

  mac_saturate #(.DW(DW), .SAT_W(SAT_W)) u_sat (
    .acc    (acc_cur),
    .prod   (prod),
    .op     (op_e),
    .sat_en (sat_en),
    .res    (acc_res)
  );

  logic [NHALF-1:0] half_ld;
  logic [DW-1:0]    half_ld_data [NHALF];
  logic [DW-1:0]    half_q       [NHALF];

  assign half_ld         = {hi_ld, lo_ld};
  assign half_ld_data[0] = lo_ld_data;
  assign half_ld_data[1] = hi_ld_data;

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    mac_acc_reg #(.DW(DW)) u_reg (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .clr      (acc_clr),
      .ld       (half_ld[g]),
      .ld_data  (half_ld_data[g]),
      .upd      (op_valid),
      .upd_data (acc_res[g*DW +: DW]),
      .q        (half_q[g])
    );
  end

  assign acc_lo = half_q[0];
  assign acc_hi = half_q[1];
endmodule

// File: rtl/sat_mac_unit_chk.sv
module sat_mac_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_int_n,
  input logic          op_valid,
  input logic          op_sel,
  input logic          sat_en,
  input logic          acc_clr,
  input logic          hi_ld,
  input logic [DW-1:0] hi_ld_data,
  input logic          lo_ld,
  input logic [DW-1:0] lo_ld_data,
  input logic [DW-1:0] acc_hi,
  input logic [DW-1:0] acc_lo
);
  localparam logic [DW-1:0] WMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] WMIN = {1'b1, {(DW-1){1'b0}}};

  logic plain_op;
  assign plain_op = op_valid && !acc_clr && !hi_ld && !lo_ld;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_clr |=> (acc_hi == '0) && (acc_lo == '0)); // R7

  AST_LOAD_HI: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hi_ld && !acc_clr) |=> acc_hi == $past(hi_ld_data)); // R8

  AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lo_ld && !acc_clr) |=> acc_lo == $past(lo_ld_data)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!op_valid && !acc_clr && !hi_ld && !lo_ld) |=> $stable(acc_hi) && $stable(acc_lo)); // R6

  AST_LONG_SAT_RANGE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (plain_op && !op_sel && sat_en) |=>
      ((acc_hi[DW-1:15] == '0) || (acc_hi[DW-1:15] == '1))); // R4

  AST_WORD_SAT_FORM: assert property (@(posedge clk) disable iff (!rst_int_n)
    (plain_op && op_sel && sat_en) |=>
      ((acc_hi == '0 && !acc_lo[DW-1]) || (acc_hi == '1 && acc_lo[DW-1]) ||
       (acc_hi == DW'(1) && (acc_lo == WMAX || acc_lo == WMIN)))); // R5
endmodule

bind sat_mac_unit sat_mac_unit_chk #(.DW(DW)) u_chk (.*);

// File: tb/sat_mac_unit_tb.sv
module sat_mac_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_sel, sat_en, acc_clr, hi_ld, lo_ld;
  logic [31:0] opnd_a, opnd_b, hi_ld_data, lo_ld_data;
  logic [31:0] acc_hi, acc_lo;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] mdl;

  always #4 clk = ~clk;

  sat_mac_unit u_dut (.*);

  // {op, sat, a, b, init_hi, init_lo, exp_hi, exp_lo}
  localparam int NV = 11;
  localparam logic [193:0] VEC [NV] = '{
    {1'b0,1'b0,32'h00000003,32'hFFFFFFFB,32'h00000000,32'h00000000,32'hFFFFFFFF,32'hFFFFFFF1},
    {1'b0,1'b0,32'h00000001,32'h00000001,32'h00000000,32'hFFFFFFFF,32'h00000001,32'h00000000},
    {1'b1,1'b0,32'h1234FFFE,32'hABCD0003,32'h00000000,32'h00000000,32'hFFFFFFFF,32'hFFFFFFFA},
    {1'b0,1'b1,32'h00000100,32'h00000001,32'h00007FFF,32'hFFFFFFF0,32'h00007FFF,32'hFFFFFFFF},
    {1'b0,1'b1,32'hFFFFFFFF,32'h00000001,32'hFFFF8000,32'h00000000,32'hFFFF8000,32'h00000000},
    {1'b0,1'b1,32'h00000002,32'h00000003,32'h00001234,32'h00000000,32'h00001234,32'h00000006},
    {1'b1,1'b1,32'h00000001,32'h00000001,32'h00000000,32'h7FFFFFFF,32'h00000001,32'h7FFFFFFF},
    {1'b1,1'b1,32'h0000FFFF,32'h00000001,32'hFFFFFFFF,32'h80000000,32'h00000001,32'h80000000},
    {1'b1,1'b1,32'h00008000,32'h00008000,32'h00000000,32'h00000010,32'h00000000,32'h40000010},
    {1'b0,1'b0,32'h00000001,32'h00000001,32'h7FFFFFFF,32'hFFFFFFFF,32'h80000000,32'h00000000},
    {1'b0,1'b0,32'h80000000,32'h80000000,32'h00000000,32'h00000000,32'h40000000,32'h00000000}
  };

  function automatic logic [63:0] ref_mac(logic [63:0] acc, logic op, logic sat,
                                          logic [31:0] a, logic [31:0] b);
    logic signed [127:0] ea, eb, s;
    logic signed [127:0] l_max, l_min, w_max, w_min;
    l_max = 128'sd140737488355327;
    l_min = -128'sd140737488355328;
    w_max = 128'sd2147483647;
    w_min = -128'sd2147483648;
    if (op) begin
      ea = {{112{a[15]}}, a[15:0]};
      eb = {{112{b[15]}}, b[15:0]};
    end else begin
      ea = {{96{a[31]}}, a};
      eb = {{96{b[31]}}, b};
    end
    s = {{64{acc[63]}}, acc} + ea * eb;
    if (!sat) return s[63:0];
    if (!op) begin
      if (s < l_min) return 64'hFFFF8000_00000000;
      if (s > l_max) return 64'h00007FFF_FFFFFFFF;
    end else begin
      if (s < w_min) return {32'd1, 32'h80000000};
      if (s > w_max) return {32'd1, 32'h7FFFFFFF};
    end
    return s[63:0];
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    op_valid = 0; op_sel = 0; sat_en = 0; acc_clr = 0;
    hi_ld = 0; lo_ld = 0; opnd_a = 0; opnd_b = 0; hi_ld_data = 0; lo_ld_data = 0;
  endtask

  task automatic load_acc(input logic [31:0] h, input logic [31:0] l);
    hi_ld = 1; lo_ld = 1; hi_ld_data = h; lo_ld_data = l;
    @(negedge clk);
    idle_in();
    mdl = {h, l};
  endtask

  task automatic do_mac(input logic op, input logic sat, input logic [31:0] a, input logic [31:0] b);
    op_valid = 1; op_sel = op; sat_en = sat; opnd_a = a; opnd_b = b;
    @(negedge clk);
    idle_in();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R6 watchdog: actual still running expected finished");
    report();
    $finish;
  end

  initial begin
    rst_n = 0;
    idle_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check64("R1 reset state", {acc_hi, acc_lo}, 64'h0);

    // Table of hand-derived vectors, R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      logic [193:0] v;
      v = VEC[i];
      load_acc(v[127:96], v[95:64]);
      do_mac(v[193], v[192], v[191:160], v[159:128]);
      check64($sformatf("R2/R3/R4/R5 vector %0d", i), {acc_hi, acc_lo}, v[63:0]);
    end

    // Word form upper operand bits ignored: R3
    load_acc(32'h0, 32'h0);
    do_mac(1'b1, 1'b0, 32'hFFFF0007, 32'h7FFF0002);
    check64("R3 upper bits ignored", {acc_hi, acc_lo}, 64'd14);

    // Hold without strobe: R6
    opnd_a = 32'h12345678; opnd_b = 32'h9ABCDEF0; op_sel = 0;
    repeat (3) @(negedge clk);
    idle_in();
    check64("R6 hold without strobe", {acc_hi, acc_lo}, 64'd14);

    // Clear beats load and accumulate: R7
    load_acc(32'h11112222, 32'h33334444);
    acc_clr = 1; hi_ld = 1; hi_ld_data = 32'hDEADBEEF; lo_ld = 1; lo_ld_data = 32'h1;
    op_valid = 1; opnd_a = 32'd5; opnd_b = 32'd5;
    @(negedge clk);
    idle_in();
    check64("R7 clear priority", {acc_hi, acc_lo}, 64'h0);

    // Per-half load priority: R8
    load_acc(32'h0, 32'h5);
    op_valid = 1; opnd_a = 32'd2; opnd_b = 32'd3; hi_ld = 1; hi_ld_data = 32'h0000ABCD;
    @(negedge clk);
    idle_in();
    check64("R8 hi load with accumulate", {acc_hi, acc_lo}, {32'h0000ABCD, 32'h0000000B});
    load_acc(32'h7, 32'h5);
    op_valid = 1; opnd_a = 32'hFFFFFFFF; opnd_b = 32'd1; lo_ld = 1; lo_ld_data = 32'h00C0FFEE;
    @(negedge clk);
    idle_in();
    check64("R8 lo load with accumulate", {acc_hi, acc_lo}, {32'h00000007, 32'h00C0FFEE});

    // Random against 128-bit model: R2 R3 R4 R5
    load_acc(32'h0, 32'h0);
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 300; i++) begin
        logic [31:0] a, b;
        logic [63:0] exp_v;
        if ($urandom_range(15) == 0) load_acc($urandom, $urandom);
        a = $urandom; b = $urandom;
        if (i % 3 == 0) a = $signed(a) >>> 18;
        exp_v = ref_mac(mdl, m[0], m[1], a, b);
        do_mac(m[0], m[1], a, b);
        check64($sformatf("R2/R3/R4/R5 random op=%0d sat=%0d step %0d", m[0], m[1], i),
                {acc_hi, acc_lo}, exp_v);
        mdl = exp_v;
      end
    end

    // Synchronous reset release: R9
    load_acc(32'h55, 32'h66);
    rst_n = 0;
    @(negedge clk);
    check64("R9 async reset clears", {acc_hi, acc_lo}, 64'h0);
    rst_n = 1;
    hi_ld = 1; hi_ld_data = 32'hCAFE0001; lo_ld = 1; lo_ld_data = 32'h2;
    @(negedge clk);
    check64("R9 first edge ignored", {acc_hi, acc_lo}, 64'h0);
    @(negedge clk);
    check64("R9 second edge ignored", {acc_hi, acc_lo}, 64'h0);
    @(negedge clk);
    check64("R9 third edge applies", {acc_hi, acc_lo}, {32'hCAFE0001, 32'h2});
    idle_in();
    @(negedge clk);

    report();
    $finish;
  end
endmodule